// File: doc/BRIEF.md
# Ring Node Transfer Forwarder

This block is the forwarding stage of one node on a one-way ring of replicated-memory nodes. Each transfer on the ring is a single beat that carries a memory address, a data word and the 8-bit ID of the node that first put it on the ring. The forwarder takes transfers from the upstream link and passes them to the downstream link. It removes transfers that this node sent, because those have now been all the way round the ring. It also removes transfers that arrive marked with a detected error. Foreign transfers that arrive without error are also written into the local memory at the same address.

Write transfers that start at this node are merged into the outgoing stream. They go out only in slots where no pass-through transfer is waiting, and they are stamped with the node's own ID. A status flag reports that the node's own traffic keeps coming back, which shows the ring is unbroken. Software can clear this flag, and it also clears itself after a programmable quiet period.

Top module: `ring_fwd`

## Requirements
- R1: A received transfer whose origin differs from `node_id` and whose `rx_err` is low appears on `tx_*` with its address, data and origin unchanged. Forwarded transfers leave in the order they were accepted.
- R2: A received transfer whose origin equals `node_id` is accepted and never appears on `tx_*`.
- R3: A received transfer with `rx_err` high is accepted and never appears on `tx_*`. It never causes a memory write.
- R4: `err_irq` is high for exactly one cycle, in the cycle after an errored transfer is accepted, and only when `err_arm` was high at acceptance. Otherwise it stays low.
- R5: A forwarded transfer (R1) raises `mem_wr_en` for one cycle, in the cycle after it is accepted, with `mem_wr_addr`/`mem_wr_data` equal to its address and data.
- R6: A local transfer accepted on `loc_*` appears on `tx_*` with its address and data, and with origin equal to `node_id`.
- R7: While a forwardable transfer is offered on `rx_*`, `loc_ready` is low. The pass-through transfer is taken first, and the local one goes in the next free slot.
- R8: While `tx_valid` is high and `tx_ready` is low, the `tx_*` contents hold, and forwardable and local transfers are not accepted. Transfers to be removed (R2, R3) are still accepted. No transfer is lost.
- R9: `ring_ok` goes high in the cycle after an error-free own-origin transfer is accepted.
- R10: A one-cycle `ring_ok_clr` pulse clears `ring_ok` at the next edge. A return in that same cycle takes priority.
- R11: If no own-origin transfer returns, `ring_ok` stays high for `RING_TIMEOUT` cycles after it is set and then falls.
- R12: While reset is held, `tx_valid`, `mem_wr_en`, `err_irq` and `ring_ok` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| node_id | input | 8 | Static ID of this node |
| err_arm | input | 1 | Enables the error interrupt request |
| ring_ok_clr | input | 1 | Software clear of the ring status flag |
| rx_valid | input | 1 | Upstream transfer offered |
| rx_ready | output | 1 | Upstream transfer accepted this cycle |
| rx_addr | input | 20 | Upstream transfer address |
| rx_data | input | 32 | Upstream transfer data |
| rx_origin | input | 8 | Upstream transfer origin ID |
| rx_err | input | 1 | Upstream transfer carries a detected error |
| loc_valid | input | 1 | Local write transfer offered |
| loc_ready | output | 1 | Local transfer accepted this cycle |
| loc_addr | input | 20 | Local transfer address |
| loc_data | input | 32 | Local transfer data |
| tx_valid | output | 1 | Downstream transfer present |
| tx_ready | input | 1 | Downstream accepts the transfer |
| tx_addr | output | 20 | Downstream transfer address |
| tx_data | output | 32 | Downstream transfer data |
| tx_origin | output | 8 | Downstream transfer origin ID |
| mem_wr_en | output | 1 | Local memory write strobe |
| mem_wr_addr | output | 20 | Local memory write address |
| mem_wr_data | output | 32 | Local memory write data |
| err_irq | output | 1 | One-cycle error interrupt request |
| ring_ok | output | 1 | Own transfers are returning |

## Verification
Every result is one register away from its handshake. A transfer accepted at a clock edge is on `tx_*` right after that edge. The memory write, the interrupt pulse and a ring-status change all show in the cycle that follows the accepting edge. The bench changes inputs on falling edges and reads outputs a moment later. A driver records the expected downstream items and memory writes only at the edge where its handshake completes. A monitor then compares them in the very next sampling slot, so an item that is late, early, extra or missing shows up as a mismatch. The ring timeout is counted in whole cycles from the setting edge, and the flag is sampled on both sides of the edge where it should fall.

// File: rtl/rf_pkg.sv
// Package: shared widths and the single-beat transfer type of the ring.
package rf_pkg;
    localparam int ID_W   = 8;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [ID_W-1:0]   origin;
    } xfer_t;
endpackage

// File: rtl/rf_classify.sv
// Module: rf_classify
// Sorts an upstream transfer into one of three kinds: returning own
// traffic, errored traffic, or traffic to forward.
// Assumes: node_id is static while traffic flows.
module rf_classify
    import rf_pkg::*;
(
    input  logic [ID_W-1:0] origin,
    input  logic [ID_W-1:0] node_id,
    input  logic            err,
    output logic            is_own,
    output logic            is_drop,
    output logic            is_fwd
);
    // Purpose: origin compare and removal decision.
    always_comb begin
        is_own  = (origin == node_id);
        is_drop = is_own || err;
        is_fwd  = !is_drop;
    end
endmodule

// File: rtl/rf_out_stage.sv
// Module: rf_out_stage
// One-entry output register with fixed-priority insertion. A pass-through
// transfer always wins over a local one. Every transfer is one beat, so a
// local insertion can only ever fall between two forwarded transfers.
// Assumes: rx_offer is held until take_rx; tx_ready may drop at any time.
module rf_out_stage
    import rf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rx_offer,
    input  xfer_t rx_item,
    input  logic  loc_offer,
    input  xfer_t loc_item,
    input  logic  tx_ready,
    output logic  tx_valid,
    output xfer_t tx_item,
    output logic  out_free,
    output logic  take_rx,
    output logic  take_loc
);
    logic  vld_q;
    xfer_t item_q;

    // Purpose: slot is free when empty or drained this cycle; grant by priority.
    always_comb begin
        out_free = !vld_q || tx_ready;
        take_rx  = rx_offer && out_free;
        take_loc = loc_offer && out_free && !rx_offer;
    end

    // Purpose: load the granted transfer or empty the slot once drained.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            item_q <= '0;
        end else if (take_rx || take_loc) begin
            vld_q  <= 1'b1;
            item_q <= take_rx ? rx_item : loc_item;
        end else if (tx_ready) begin
            vld_q  <= 1'b0;
        end
    end

    assign tx_valid = vld_q;
    assign tx_item  = item_q;

    // R8: a stalled output keeps its transfer.
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_item));
    // R7: the local request never gets the slot while pass-through traffic is offered.
    p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_offer && loc_offer && out_free |=> tx_item == $past(rx_item));
endmodule

// File: rtl/rf_ring_watch.sv
// Module: rf_ring_watch
// Ring-intact flag. It is set when own traffic returns and cleared by a
// software pulse or after RING_TIMEOUT quiet cycles.
// Assumes: ret is a one-cycle event per returned transfer.
module rf_ring_watch #(
    parameter int RING_TIMEOUT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ret,
    input  logic clr,
    output logic ring_ok
);
    localparam int CNT_W = $clog2(RING_TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RING_TIMEOUT - 1);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: set on return, clear on software pulse or on quiet-period expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_ok <= 1'b0;
            cnt_q   <= '0;
        end else if (ret) begin
            ring_ok <= 1'b1;
            cnt_q   <= '0;
        end else if (clr) begin
            ring_ok <= 1'b0;
            cnt_q   <= '0;
        end else if (ring_ok) begin
            if (cnt_q == LAST) begin
                ring_ok <= 1'b0;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R9: a return always sets the flag.
    p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ret |=> ring_ok);
    // R10: a clear without a return drops the flag.
    p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !ret |=> !ring_ok);
    // R11: expiry of the quiet window drops the flag.
    p_timeout_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ring_ok && !ret && !clr && cnt_q == LAST |=> !ring_ok);
endmodule

// File: rtl/ring_fwd.sv
// Module: ring_fwd (top)
// Forwarding logic of one ring node. It removes own and errored transfers,
// copies foreign good transfers into local memory, and splices local writes
// into gaps in the pass-through stream.
// Assumes: node_id is static; all ring ports use valid/ready handshakes.
module ring_fwd
    import rf_pkg::*;
#(
    parameter int RING_TIMEOUT = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   node_id,
    input  logic              err_arm,
    input  logic              ring_ok_clr,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [ID_W-1:0]   rx_origin,
    input  logic              rx_err,
    input  logic              loc_valid,
    output logic              loc_ready,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [DATA_W-1:0] loc_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [ADDR_W-1:0] tx_addr,
    output logic [DATA_W-1:0] tx_data,
    output logic [ID_W-1:0]   tx_origin,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              err_irq,
    output logic              ring_ok
);
    logic  is_own, is_drop, is_fwd;
    logic  out_free, take_rx, take_loc, rx_acc, ret;
    xfer_t rx_item, loc_item, tx_item;

    rf_classify u_cls (
        .origin (rx_origin),
        .node_id(node_id),
        .err    (rx_err),
        .is_own (is_own),
        .is_drop(is_drop),
        .is_fwd (is_fwd)
    );

    // Purpose: pack both sources; local traffic is stamped with this node's ID.
    always_comb begin
        rx_item  = '{addr: rx_addr,  data: rx_data,  origin: rx_origin};
        loc_item = '{addr: loc_addr, data: loc_data, origin: node_id};
    end

    rf_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_offer (rx_valid && is_fwd),
        .rx_item  (rx_item),
        .loc_offer(loc_valid),
        .loc_item (loc_item),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_item  (tx_item),
        .out_free (out_free),
        .take_rx  (take_rx),
        .take_loc (take_loc)
    );

    // Purpose: handshakes; removed transfers are absorbed even during a stall.
    always_comb begin
        rx_ready  = is_drop || out_free;
        loc_ready = out_free && !(rx_valid && is_fwd);
        rx_acc    = rx_valid && rx_ready;
        ret       = rx_acc && is_own && !rx_err;
        tx_addr   = tx_item.addr;
        tx_data   = tx_item.data;
        tx_origin = tx_item.origin;
    end

    // Purpose: local memory copy of foreign traffic and error interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_wr_en   <= 1'b0;
            mem_wr_addr <= '0;
            mem_wr_data <= '0;
            err_irq     <= 1'b0;
        end else begin
            mem_wr_en   <= rx_acc && is_fwd;
            mem_wr_addr <= rx_addr;
            mem_wr_data <= rx_data;
            err_irq     <= rx_acc && rx_err && err_arm;
        end
    end

    rf_ring_watch #(.RING_TIMEOUT(RING_TIMEOUT)) u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .ret    (ret),
        .clr    (ring_ok_clr),
        .ring_ok(ring_ok)
    );

    // R3: an errored transfer never reaches memory.
    p_no_mem_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready && rx_err |=> !mem_wr_en);
    // R4: an armed error acceptance raises the request next cycle.
    p_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ready && rx_err && err_arm |=> err_irq);
    // R2: an own-origin transfer is never loaded into the output.
    p_drop_own_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_origin == node_id |-> !take_rx);
    // R6: an accepted local transfer leaves with this node's origin.
    p_loc_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        loc_valid && loc_ready |=> tx_valid && tx_origin == node_id);
endmodule

// File: tb/tb_ring_fwd.sv
module tb_ring_fwd;
    localparam int TMO = 20;
    localparam logic [7:0] ME = 8'h2A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  node_id = ME;
    logic        err_arm = 1'b0, ring_ok_clr = 1'b0;
    logic        rx_valid = 1'b0, rx_err = 1'b0, loc_valid = 1'b0, tx_ready = 1'b1;
    logic [19:0] rx_addr = '0, loc_addr = '0;
    logic [31:0] rx_data = '0, loc_data = '0;
    logic [7:0]  rx_origin = '0;
    logic        rx_ready, loc_ready, tx_valid, mem_wr_en, err_irq, ring_ok;
    logic [19:0] tx_addr, mem_wr_addr;
    logic [31:0] tx_data, mem_wr_data;
    logic [7:0]  tx_origin;

    int checks = 0, errors = 0, irq_seen = 0;
    bit done = 0;
    logic [59:0] tx_q[$];
    logic [51:0] mem_q[$];

    always #4 clk = ~clk;

    ring_fwd #(.RING_TIMEOUT(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .node_id(node_id), .err_arm(err_arm),
        .ring_ok_clr(ring_ok_clr), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_addr(rx_addr), .rx_data(rx_data), .rx_origin(rx_origin), .rx_err(rx_err),
        .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_addr(loc_addr),
        .loc_data(loc_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_addr(tx_addr), .tx_data(tx_data), .tx_origin(tx_origin),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .err_irq(err_irq), .ring_ok(ring_ok)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Driver: offer one upstream transfer, record expectations at the handshake edge.
    task automatic send_rx(input logic [19:0] a, input logic [31:0] d,
                           input logic [7:0] o, input logic e);
        @(negedge clk);
        rx_valid = 1; rx_addr = a; rx_data = d; rx_origin = o; rx_err = e;
        #1;
        while (!rx_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        if (o != ME && !e) begin
            tx_q.push_back({a, d, o});
            mem_q.push_back({a, d});
        end
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic send_loc(input logic [19:0] a, input logic [31:0] d);
        @(negedge clk);
        loc_valid = 1; loc_addr = a; loc_data = d;
        #1;
        while (!loc_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        tx_q.push_back({a, d, ME});
        @(negedge clk);
        loc_valid = 0;
    endtask

    // Monitor: compare outputs in the sampling slot after each falling edge.
    initial begin
        forever begin
            @(negedge clk); #1;
            if (rst_n && tx_valid && tx_ready) begin
                if (tx_q.size() == 0)
                    chk(0, "R1/R2/R3 unexpected tx", {4'h0, tx_addr, tx_data, tx_origin}, 0);
                else begin
                    logic [59:0] e;
                    e = tx_q.pop_front();
                    chk({tx_addr, tx_data, tx_origin} == e, "R1/R6 tx item",
                        {4'h0, tx_addr, tx_data, tx_origin}, {4'h0, e});
                end
            end
            if (rst_n && mem_wr_en) begin
                if (mem_q.size() == 0)
                    chk(0, "R3/R5 unexpected mem write", {12'h0, mem_wr_addr, mem_wr_data}, 0);
                else begin
                    logic [51:0] m;
                    m = mem_q.pop_front();
                    chk({mem_wr_addr, mem_wr_data} == m, "R5 mem write",
                        {12'h0, mem_wr_addr, mem_wr_data}, {12'h0, m});
                end
            end
            if (rst_n && err_irq) irq_seen++;
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R12: reset state
        chk(!tx_valid && !mem_wr_en && !err_irq && !ring_ok, "R12 reset outputs",
            {tx_valid, mem_wr_en, err_irq, ring_ok}, 0);
        @(negedge clk); rst_n = 1;

        // R1, R5: foreign good traffic forwarded and copied to memory
        send_rx(20'h00010, 32'hDEAD0001, 8'h01, 0);
        send_rx(20'hFFFFF, 32'hFFFFFFFF, 8'hFF, 0);
        send_rx(20'h00000, 32'h00000000, 8'h00, 0);

        // R2, R9: own return removed, ring flag rises
        send_rx(20'h00123, 32'h11112222, ME, 0);
        chk(ring_ok == 1, "R9 ring_ok set", ring_ok, 1);

        // R11: quiet-period expiry
        repeat (TMO - 1) @(negedge clk);
        #1 chk(ring_ok == 1, "R11 ring_ok before expiry", ring_ok, 1);
        @(negedge clk);
        #1 chk(ring_ok == 0, "R11 ring_ok after expiry", ring_ok, 0);

        // R10: software clear
        send_rx(20'h00124, 32'h33334444, ME, 0);
        chk(ring_ok == 1, "R9 ring_ok set again", ring_ok, 1);
        ring_ok_clr = 1;
        @(negedge clk); ring_ok_clr = 0;
        #1 chk(ring_ok == 0, "R10 ring_ok cleared", ring_ok, 0);

        // R3, R4: errored traffic removed, interrupt only when armed
        err_arm = 1;
        send_rx(20'h00200, 32'hBAD00001, 8'h05, 1);
        err_arm = 0;
        send_rx(20'h00201, 32'hBAD00002, 8'h06, 1);
        send_rx(20'h00202, 32'hBAD00003, ME, 1);
        chk(ring_ok == 0, "R9 errored own return leaves flag low", ring_ok, 0);
        repeat (2) @(negedge clk);
        chk(irq_seen == 1, "R4 irq pulses", irq_seen, 1);

        // R6: local write stamped with own ID
        send_loc(20'h00300, 32'hCAFE0001);

        // R7: pass-through first when both offered
        @(negedge clk);
        rx_valid = 1; rx_addr = 20'h00400; rx_data = 32'h0A0A0A0A; rx_origin = 8'h07; rx_err = 0;
        loc_valid = 1; loc_addr = 20'h00401; loc_data = 32'h0B0B0B0B;
        #1 chk(rx_ready && !loc_ready, "R7 local held off", {rx_ready, loc_ready}, 2'b10);
        @(posedge clk);
        tx_q.push_back({20'h00400, 32'h0A0A0A0A, 8'h07});
        mem_q.push_back({20'h00400, 32'h0A0A0A0A});
        @(negedge clk); rx_valid = 0;
        #1 chk(loc_ready == 1, "R7 local takes next slot", loc_ready, 1);
        @(posedge clk);
        tx_q.push_back({20'h00401, 32'h0B0B0B0B, ME});
        @(negedge clk); loc_valid = 0;

        // R8: downstream stall
        @(negedge clk); tx_ready = 0;
        send_rx(20'h00500, 32'h55550001, 8'h09, 0);
        rx_valid = 1; rx_addr = 20'h00501; rx_data = 32'h55550002; rx_origin = 8'h0A; rx_err = 0;
        loc_valid = 1; loc_addr = 20'h00502; loc_data = 32'h55550003;
        #1 chk(!rx_ready && !loc_ready, "R8 inputs blocked", {rx_ready, loc_ready}, 0);
        repeat (3) @(negedge clk);
        #1 chk(tx_valid && tx_addr == 20'h00500 && tx_data == 32'h55550001, "R8 output held",
               {tx_valid, tx_addr, tx_data}, {1'b1, 20'h00500, 32'h55550001});
        rx_origin = ME;
        #1 chk(rx_ready == 1, "R8 own return absorbed while stalled", rx_ready, 1);
        @(negedge clk);
        rx_valid = 0; loc_valid = 0;
        @(negedge clk); tx_ready = 1;
        send_rx(20'h00501, 32'h55550002, 8'h0A, 0);
        send_loc(20'h00502, 32'h55550003);

        repeat (5) @(negedge clk);
        chk(tx_q.size() == 0, "R1 all forwarded items delivered", tx_q.size(), 0);
        chk(mem_q.size() == 0, "R5 all memory writes seen", mem_q.size(), 0);
        chk(irq_seen == 1, "R4 no extra irq", irq_seen, 1);
        summary();
    end
endmodule